// File: doc/BRIEF.md
# Cache Victim Selection Unit

This unit decides which way of a set-associative cache gives up its line when a fill arrives. It keeps only the per-set replacement order, and no tags or data. A requester presents a set index together with the valid and modified bits of every way in that set. One cycle later the unit reports the way to be replaced. It also raises a flag when that way holds a modified line, which must then be written back before the fill overwrites it.

Two ordering policies are available, and a parameter picks one at build time:
- **Recency order (LRU).** Every hit and every allocation makes the touched way the newest. This suits instruction and second-level caches.
- **Allocation order (LRA).** Only allocations reorder the set, and hits leave the order alone. This suits a data cache.

A second parameter turns the writeback flag on for the data-cache and second-level builds. The instruction-cache build leaves it off.

The control is a two-state machine:
- **ST_IDLE** is the resting state.
- **ST_REPORT** is the state in which the outputs carry a victim.

The machine has these transitions:
- **T_ACCEPT** goes from ST_IDLE to ST_REPORT when a request is seen.
- **T_CHAIN** goes from ST_REPORT to ST_REPORT when a new request arrives in the reporting cycle.
- **T_DONE** goes from ST_REPORT to ST_IDLE when no request follows.

Top module: `vsel_top`

## Requirements
- R1: `vict_vld` is high in exactly the cycle after a cycle with `req` high, and low in every other cycle, including the first cycle after reset. `vict_way` and `vict_wb` describe the request of the previous cycle.
- R2: If any bit of `req_valid` is 0 (bit i belongs to way i), the victim is the lowest-numbered way whose valid bit is 0, and `vict_wb` is 0.
- R3: In the recency-order build with all ways valid, the victim is the way whose most recent hit or allocation lies furthest in the past.
- R4: In the allocation-order build with all ways valid, the victim is the way allocated longest ago, and hits do not change which way is chosen.
- R5: With all ways valid, `vict_wb` equals `req_dirty` bit (victim way) when WB_ENABLE is 1. It is always 0 when WB_ENABLE is 0.
- R6: After reset, every set orders its ways from way 0 (oldest) to the highest way (newest), so a full set first yields way 0.
- R7: A hit or allocation on one set leaves the order of every other set unchanged.
- R8: A request reads the order as it stood before the updates of its own cycle. If a hit and an allocation target the same set in one cycle, only the allocation takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Victim request strobe |
| req_set | input | SET_W | Set index of the request |
| req_valid | input | NUM_WAYS | Valid bit per way of the requested set |
| req_dirty | input | NUM_WAYS | Modified bit per way of the requested set |
| hit_en | input | 1 | A hit occurred |
| hit_set | input | SET_W | Set of the hit |
| hit_way | input | WAY_W | Way of the hit |
| alloc_en | input | 1 | A line was allocated |
| alloc_set | input | SET_W | Set of the allocation |
| alloc_way | input | WAY_W | Way that received the line |
| vict_vld | output | 1 | Victim outputs are meaningful this cycle |
| vict_way | output | WAY_W | Chosen victim way |
| vict_wb | output | 1 | Victim is modified and must be written back first |

## Verification
The bench drives three builds from the same inputs: recency order with the writeback flag, allocation order with the writeback flag, and recency order without it.

Directed patterns cover the following cases:
- Sets with invalid holes at different positions, which separate the invalid-first rule from the ordering rule.
- Hits followed by requests, which are the one pattern on which the two policies disagree.
- A hit and an allocation on the same set in one cycle, which shows which of the two updates wins.
- A request and an allocation on the same set in one cycle, which shows that the order is read before the update.
- Requests on untouched sets, which show that the sets are kept apart.

Random traffic then mixes requests, hits and allocations over a few sets with mostly full valid masks and random modified bits. It is checked against orderings kept by the bench.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    typedef enum logic {
        POL_LRU = 1'b0,
        POL_LRA = 1'b1
    } policy_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } vsel_state_e;

endpackage

// File: rtl/vsel_rank_store.sv
module vsel_rank_store
    import vsel_pkg::*;
#(
    parameter int      NUM_WAYS = 4,
    parameter int      NUM_SETS = 16,
    parameter policy_e POLICY   = POL_LRU,
    localparam int     WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int     SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SET_W-1:0]                 rd_set,
    output logic [NUM_WAYS-1:0][WAY_W-1:0]   rd_rank,
    input  logic                             hit_en,
    input  logic [SET_W-1:0]                 hit_set,
    input  logic [WAY_W-1:0]                 hit_way,
    input  logic                             alloc_en,
    input  logic [SET_W-1:0]                 alloc_set,
    input  logic [WAY_W-1:0]                 alloc_way
);

    localparam bit HIT_MOVES = (POLICY == POL_LRU);
    localparam logic [WAY_W-1:0] NEWEST = WAY_W'(NUM_WAYS - 1);

    logic [NUM_SETS-1:0][NUM_WAYS-1:0][WAY_W-1:0] all_rank;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic [NUM_WAYS-1:0][WAY_W-1:0] rank_q;
        logic                           alloc_here;
        logic                           hit_here;
        logic                           touch;
        logic [WAY_W-1:0]               touch_way;

        always_comb begin
            alloc_here = alloc_en && (alloc_set == SET_W'(s));
            hit_here   = HIT_MOVES && hit_en && (hit_set == SET_W'(s));
            touch      = alloc_here || hit_here;
            touch_way  = alloc_here ? alloc_way : hit_way;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    rank_q[w] <= WAY_W'(w);
                end
            end else if (touch) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    if (WAY_W'(w) == touch_way) begin
                        rank_q[w] <= NEWEST;
                    end else if (rank_q[w] > rank_q[touch_way]) begin
                        rank_q[w] <= rank_q[w] - 1'b1;
                    end
                end
            end
        end

        assign all_rank[s] = rank_q;
    end

    assign rd_rank = all_rank[rd_set];

endmodule

// File: rtl/vsel_pick.sv
module vsel_pick #(
    parameter int  NUM_WAYS  = 4,
    parameter bit  WB_ENABLE = 1'b1,
    localparam int WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0][WAY_W-1:0] rank,
    input  logic [NUM_WAYS-1:0]            valid,
    input  logic [NUM_WAYS-1:0]            dirty,
    output logic [WAY_W-1:0]               way,
    output logic                           wb
);

    logic             full;
    logic             hole_found;
    logic [WAY_W-1:0] hole_way;
    logic [WAY_W-1:0] oldest_way;

    always_comb begin
        full       = &valid;
        hole_found = 1'b0;
        hole_way   = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!valid[w] && !hole_found) begin
                hole_way   = WAY_W'(w);
                hole_found = 1'b1;
            end
        end
    end

    always_comb begin
        oldest_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (rank[w] == '0) begin
                oldest_way = WAY_W'(w);
            end
        end
    end

    always_comb begin
        way = full ? oldest_way : hole_way;
        wb  = WB_ENABLE && full && dirty[oldest_way];
    end

endmodule

// File: rtl/vsel_top.sv
module vsel_top
    import vsel_pkg::*;
#(
    parameter int      NUM_WAYS  = 4,
    parameter int      NUM_SETS  = 16,
    parameter policy_e POLICY    = POL_LRU,
    parameter bit      WB_ENABLE = 1'b1,
    localparam int     WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int     SET_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [SET_W-1:0]    req_set,
    input  logic [NUM_WAYS-1:0] req_valid,
    input  logic [NUM_WAYS-1:0] req_dirty,
    input  logic                hit_en,
    input  logic [SET_W-1:0]    hit_set,
    input  logic [WAY_W-1:0]    hit_way,
    input  logic                alloc_en,
    input  logic [SET_W-1:0]    alloc_set,
    input  logic [WAY_W-1:0]    alloc_way,
    output logic                vict_vld,
    output logic [WAY_W-1:0]    vict_way,
    output logic                vict_wb
);

    vsel_state_e                    state_q;
    vsel_state_e                    state_d;
    logic [NUM_WAYS-1:0][WAY_W-1:0] cur_rank;
    logic [WAY_W-1:0]               pick_way;
    logic                           pick_wb;
    logic [WAY_W-1:0]               way_q;
    logic                           wb_q;

    vsel_rank_store #(
        .NUM_WAYS (NUM_WAYS),
        .NUM_SETS (NUM_SETS),
        .POLICY   (POLICY)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (req_set),
        .rd_rank   (cur_rank),
        .hit_en    (hit_en),
        .hit_set   (hit_set),
        .hit_way   (hit_way),
        .alloc_en  (alloc_en),
        .alloc_set (alloc_set),
        .alloc_way (alloc_way)
    );

    vsel_pick #(
        .NUM_WAYS  (NUM_WAYS),
        .WB_ENABLE (WB_ENABLE)
    ) u_pick (
        .rank  (cur_rank),
        .valid (req_valid),
        .dirty (req_dirty),
        .way   (pick_way),
        .wb    (pick_wb)
    );

    // Next-state: T_ACCEPT, T_CHAIN, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and victim capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            way_q   <= '0;
            wb_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req) begin
                way_q <= pick_way;
                wb_q  <= pick_wb;
            end
        end
    end

    // Outputs
    always_comb begin
        vict_vld = 1'b0;
        vict_way = way_q;
        vict_wb  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                vict_vld = 1'b0;
                vict_wb  = 1'b0;
            end
            ST_REPORT: begin
                vict_vld = 1'b1;
                vict_wb  = wb_q;
            end
            default: begin
                vict_vld = 1'b0;
                vict_wb  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/vsel_checker.sv
module vsel_checker #(
    parameter int  NUM_WAYS  = 4,
    parameter bit  WB_ENABLE = 1'b1,
    localparam int WAY_W     = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req,
    input logic [NUM_WAYS-1:0] req_valid,
    input logic [NUM_WAYS-1:0] req_dirty,
    input logic                vict_vld,
    input logic [WAY_W-1:0]    vict_way,
    input logic                vict_wb
);

    logic [NUM_WAYS-1:0] cap_valid;
    logic [NUM_WAYS-1:0] cap_dirty;
    logic [NUM_WAYS-1:0] below_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= '1;
            cap_dirty <= '0;
        end else if (req) begin
            cap_valid <= req_valid;
            cap_dirty <= req_dirty;
        end
    end

    always_comb begin
        below_mask = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            below_mask[w] = (WAY_W'(w) < vict_way);
        end
    end

    p_report_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> vict_vld);

    p_quiet_without_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !vict_vld);

    p_hole_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vict_vld && !(&cap_valid)) |->
            (!cap_valid[vict_way] && ((cap_valid & below_mask) == below_mask) && !vict_wb));

    p_wb_only_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vict_wb |-> (vict_vld && (&cap_valid) && cap_dirty[vict_way] && WB_ENABLE));

    p_wb_when_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vict_vld && (&cap_valid) && cap_dirty[vict_way] && WB_ENABLE) |-> vict_wb);

endmodule

bind vsel_top vsel_checker #(
    .NUM_WAYS  (NUM_WAYS),
    .WB_ENABLE (WB_ENABLE)
) u_vsel_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_valid (req_valid),
    .req_dirty (req_dirty),
    .vict_vld  (vict_vld),
    .vict_way  (vict_way),
    .vict_wb   (vict_wb)
);

// File: tb/vsel_top_bench.sv
`timescale 1ns/1ps
module vsel_top_bench;
    import vsel_pkg::*;

    localparam int W  = 4;
    localparam int S  = 8;
    localparam int WW = 2;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [SW-1:0] req_set = '0;
    logic [W-1:0]  req_valid = '0;
    logic [W-1:0]  req_dirty = '0;
    logic          hit_en = 1'b0;
    logic [SW-1:0] hit_set = '0;
    logic [WW-1:0] hit_way = '0;
    logic          alloc_en = 1'b0;
    logic [SW-1:0] alloc_set = '0;
    logic [WW-1:0] alloc_way = '0;

    logic          a_vld, b_vld, c_vld;
    logic [WW-1:0] a_way, b_way, c_way;
    logic          a_wb, b_wb, c_wb;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int m_lru [S][W];
    int m_lra [S][W];

    always #5 clk = ~clk;

    vsel_top #(.NUM_WAYS(W), .NUM_SETS(S), .POLICY(POL_LRU), .WB_ENABLE(1'b1)) u_vsel_top (
        .clk(clk), .rst_n(rst_n), .req(req), .req_set(req_set), .req_valid(req_valid),
        .req_dirty(req_dirty), .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way),
        .alloc_en(alloc_en), .alloc_set(alloc_set), .alloc_way(alloc_way),
        .vict_vld(a_vld), .vict_way(a_way), .vict_wb(a_wb));

    vsel_top #(.NUM_WAYS(W), .NUM_SETS(S), .POLICY(POL_LRA), .WB_ENABLE(1'b1)) u_lra (
        .clk(clk), .rst_n(rst_n), .req(req), .req_set(req_set), .req_valid(req_valid),
        .req_dirty(req_dirty), .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way),
        .alloc_en(alloc_en), .alloc_set(alloc_set), .alloc_way(alloc_way),
        .vict_vld(b_vld), .vict_way(b_way), .vict_wb(b_wb));

    vsel_top #(.NUM_WAYS(W), .NUM_SETS(S), .POLICY(POL_LRU), .WB_ENABLE(1'b0)) u_icache (
        .clk(clk), .rst_n(rst_n), .req(req), .req_set(req_set), .req_valid(req_valid),
        .req_dirty(req_dirty), .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way),
        .alloc_en(alloc_en), .alloc_set(alloc_set), .alloc_way(alloc_way),
        .vict_vld(c_vld), .vict_way(c_way), .vict_wb(c_wb));

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < S; s++) begin
            for (int w = 0; w < W; w++) begin
                m_lru[s][w] = w;
                m_lra[s][w] = w;
            end
        end
    endtask

    task automatic touch(bit lra, int s, int w);
        int r;
        r = lra ? m_lra[s][w] : m_lru[s][w];
        for (int k = 0; k < W; k++) begin
            if (k == w) begin
                if (lra) m_lra[s][k] = W - 1; else m_lru[s][k] = W - 1;
            end else if (lra && m_lra[s][k] > r) begin
                m_lra[s][k]--;
            end else if (!lra && m_lru[s][k] > r) begin
                m_lru[s][k]--;
            end
        end
    endtask

    function automatic int exp_way(bit lra, int s, logic [W-1:0] v);
        if (!(&v)) begin
            for (int w = 0; w < W; w++) if (!v[w]) return w;
        end
        for (int w = 0; w < W; w++) begin
            if ((lra ? m_lra[s][w] : m_lru[s][w]) == 0) return w;
        end
        return -1;
    endfunction

    task automatic step(string tag, bit rq, int st, logic [W-1:0] vl, logic [W-1:0] dt,
                        bit he, int hs, int hw, bit ae, int as_, int aw);
        int ea, eb;
        int wa, wb_l;
        req = rq; req_set = SW'(st); req_valid = vl; req_dirty = dt;
        hit_en = he; hit_set = SW'(hs); hit_way = WW'(hw);
        alloc_en = ae; alloc_set = SW'(as_); alloc_way = WW'(aw);
        ea = exp_way(1'b0, st, vl);
        eb = exp_way(1'b1, st, vl);
        wa = (&vl) ? int'(dt[ea]) : 0;
        wb_l = (&vl) ? int'(dt[eb]) : 0;
        // R8: alloc wins over a same-set hit; hits move only the recency order
        if (ae) begin
            touch(1'b0, as_, aw);
            touch(1'b1, as_, aw);
        end
        if (he && !(ae && as_ == hs)) touch(1'b0, hs, hw);
        @(negedge clk);
        if (rq) begin
            chk({tag, " R1 vld"}, int'(a_vld), 1);
            chk({tag, " LRU way"}, int'(a_way), ea);
            chk({tag, " LRA way"}, int'(b_way), eb);
            chk({tag, " R5 LRU wb"}, int'(a_wb), wa);
            chk({tag, " R5 LRA wb"}, int'(b_wb), wb_l);
            chk({tag, " R5 nowb"}, int'(c_wb), 0);
            chk({tag, " nowb way"}, int'(c_way), ea);
        end else begin
            chk({tag, " R1 idle vld"}, int'(a_vld) + int'(b_vld) + int'(c_vld), 0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset vld", int'(a_vld) + int'(b_vld) + int'(c_vld), 0);

        // R6: full set after reset gives way 0
        step("R6 reset order", 1, 0, 4'hF, 4'h0, 0, 0, 0, 0, 0, 0);
        // R2: holes
        step("R2 all empty", 1, 5, 4'h0, 4'hF, 0, 0, 0, 0, 0, 0);
        step("R2 hole 2", 1, 5, 4'b1011, 4'hF, 0, 0, 0, 0, 0, 0);
        step("R2 hole 3", 1, 5, 4'b0111, 4'hF, 0, 0, 0, 0, 0, 0);
        // R3/R4: allocation then hit
        step("R3 R4 alloc", 0, 0, 4'hF, 4'h0, 0, 0, 0, 1, 1, 0);
        step("R3 R4 after alloc", 1, 1, 4'hF, 4'h0, 0, 0, 0, 0, 0, 0);
        step("R4 hit ignored", 0, 0, 4'hF, 4'h0, 1, 1, 1, 0, 0, 0);
        step("R3 R4 after hit", 1, 1, 4'hF, 4'h0, 0, 0, 0, 0, 0, 0);
        // R8: same-cycle hit and alloc on one set
        step("R8 both", 0, 0, 4'hF, 4'h0, 1, 2, 1, 1, 2, 0);
        step("R8 alloc wins", 1, 2, 4'hF, 4'h0, 0, 0, 0, 0, 0, 0);
        // R7: untouched set
        step("R7 other set", 1, 3, 4'hF, 4'h0, 0, 0, 0, 0, 0, 0);
        // R5: dirty victim
        step("R5 dirty", 1, 1, 4'hF, 4'hF, 0, 0, 0, 0, 0, 0);
        step("R5 clean", 1, 1, 4'hF, 4'h0, 0, 0, 0, 0, 0, 0);
        // R8: request reads order before same-cycle alloc
        step("R8 pre-update", 1, 4, 4'hF, 4'h1, 0, 0, 0, 1, 4, 0);
        step("R8 post-update", 1, 4, 4'hF, 4'h1, 0, 0, 0, 0, 0, 0);

        seed = $urandom(32'd4242);
        for (int i = 0; i < 600; i++) begin
            bit          rq, he, ae;
            int          st, hs, hw, as_, aw;
            logic [W-1:0] vl, dt;
            rq  = ($urandom % 3) != 0;
            st  = $urandom % 3;
            vl  = (($urandom % 4) != 0) ? 4'hF : W'($urandom);
            dt  = W'($urandom);
            he  = ($urandom % 2) == 1;
            hs  = $urandom % 3;
            hw  = $urandom % W;
            ae  = ($urandom % 3) == 0;
            as_ = $urandom % 3;
            aw  = $urandom % W;
            step((&vl) ? "R3 R4 rand" : "R2 rand", rq, st, vl, dt, he, hs, hw, ae, as_, aw);
        end

        step("R1 final idle", 0, 0, 4'hF, 4'h0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule